// File: doc/BRIEF.md
# Full-Bridge Diagonal Sequencer

This block drives the four gate commands of a full bridge from a single clock. A digital triangle counter takes the place of a timing capacitor: it climbs and falls between one third and two thirds of full scale, and its turning points decide when the two diagonal pairs switch. Pair A is the lower-left plus upper-right switch (`lo1_o` with `ho2_o`). Pair B is the lower-right plus upper-left switch (`lo2_o` with `ho1_o`). Between the pairs a programmable deadtime holds every command low. Half-period and deadtime are given as clock counts. In this design one third of full scale equals the half-period count P, two thirds equals 2P, and one sixth equals P/2.

Two supply flags carry a hysteresis band. One says the supply is above the turn-on level; the other says it is still above the lower turn-off level. On turn-on, both low sides conduct while the counter climbs from zero to one third, so that the high-side supplies are charged before any high-side pulse. A shutdown input latches a fault, and only a drop below the turn-off level clears it. An external hold discharges the counter. Once the counter is below one sixth, the bridge stops with the charging enables off. After release it restarts at one third, with no precharge phase.

The controller is one state machine. Its states are:
- LOCKOUT: supply low.
- PRECHARGE: both low sides on.
- DEAD_A: gap before pair A.
- PAIR_A: pair A conducts.
- DEAD_B: gap before pair B.
- PAIR_B: pair B conducts.
- HALT: non-latched stop.
- FAULT: latched stop.

Its transitions are:
- power-good: LOCKOUT to PRECHARGE.
- third-reached: PRECHARGE to DEAD_A, and HALT to DEAD_A.
- gap-done: DEAD_A to PAIR_A, and DEAD_B to PAIR_B.
- top-reached: PAIR_A to DEAD_B.
- bottom-reached: PAIR_B to DEAD_A.
- sixth-hold: any running state to HALT.
- shutdown: any powered state to FAULT.
- power-loss: any state to LOCKOUT.

Top module: `fbridge_seq`

## Requirements
- R1: During reset and while the supply is not good (state LOCKOUT), all four gate commands and both charging enables are 0.
- R2: Turn-on needs the turn-on flag. Once running, the bridge keeps switching while only the turn-off flag is high. It stops only when the turn-off flag falls, and it stays stopped until the turn-on flag rises again.
- R3: After turn-on, `lo1_o` and `lo2_o` are both 1 and both high-side commands are 0 for exactly P cycles.
- R4: Pair A (`lo1_o`=`ho2_o`=1, pattern {lo1,lo2,ho1,ho2}=4'b1001) conducts for P−D cycles per period.
- R5: Pair B (pattern 4'b0110) conducts for P−D cycles, so the two halves are equal.
- R6: Every change between precharge, pair A and pair B passes through exactly D cycles with all four commands at 0. `loN_o` and `hoN_o` of the same leg are never 1 together.
- R7: A shutdown pulse latches FAULT with all outputs 0. Dropping only the turn-on flag does not clear it. Dropping the turn-off flag and then restoring supply restarts the bridge from precharge.
- R8: An asserted hold stops the bridge with all outputs and charging enables at 0. After release, the first nonzero pattern is pair A (4'b1001), not the precharge.
- R9: A deadtime setting of 0 is treated as 1. A half-period at or below the deadtime is raised to deadtime+1.
- R10: `boot1_en_o` equals `lo1_o` and `boot2_en_o` equals `lo2_o` in every cycle.
- R11: The shutdown, hold and supply inputs pass through two-flop synchronizers. FAULT outranks HALT: shutdown with hold active stays latched after the hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_above_on_i | input | 1 | Supply above turn-on level |
| vdd_above_off_i | input | 1 | Supply above turn-off level |
| shutdown_i | input | 1 | Latching shutdown request |
| ramp_hold_i | input | 1 | External clamp discharging the ramp |
| half_period_i | input | CNT_W | Half-period P in clock cycles |
| dead_time_i | input | CNT_W | Deadtime D in clock cycles |
| lo1_o | output | 1 | Low-side command, leg 1 |
| lo2_o | output | 1 | Low-side command, leg 2 |
| ho1_o | output | 1 | High-side command, leg 1 |
| ho2_o | output | 1 | High-side command, leg 2 |
| boot1_en_o | output | 1 | Charging enable, leg 1 high side |
| boot2_en_o | output | 1 | Charging enable, leg 2 high side |

## Verification
A rising supply flag reaches the precharge outputs on the fourth rising edge: two synchronizer flops, the power register, then the state register. Shutdown and hold act from the third edge, and a hold then needs up to 2P further cycles to discharge below one sixth. Period and deadtime results carry no fixed latency. The bench samples every pattern at the falling edge and measures the length of each run of equal patterns, so these lengths do not depend on the cycle in which a run began. Where a stop is expected, the bench first waits past the worst-case latency and then requires zero activity over a whole window.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [2:0] {
        ST_LOCKOUT,
        ST_PRECHARGE,
        ST_DEAD_A,
        ST_PAIR_A,
        ST_DEAD_B,
        ST_PAIR_B,
        ST_HALT,
        ST_FAULT
    } bridge_state_e;
endpackage

// File: rtl/fbs_sync.sv
module fbs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/fbs_ramp.sv
module fbs_ramp #(
    parameter int RW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_i,
    input  logic          hold_i,
    input  logic [RW-1:0] third_i,
    output logic          ev_third_o,
    output logic          ev_top_o,
    output logic          ev_bot_o,
    output logic          below_sixth_o
);
    localparam int AW = RW + 1;

    logic [AW-1:0] ramp_q;
    logic          up_q;
    logic [AW-1:0] lo_w, hi_w, sixth_w, r_inc, r_dn;

    assign lo_w    = AW'(third_i);
    assign hi_w    = {third_i, 1'b0};
    assign sixth_w = AW'(third_i >> 1);
    assign r_inc   = ramp_q + AW'(1);
    assign r_dn    = (ramp_q == '0) ? '0 : ramp_q - AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q <= '0;
            up_q   <= 1'b1;
        end else if (zero_i) begin
            ramp_q <= '0;
            up_q   <= 1'b1;
        end else if (hold_i) begin
            ramp_q <= r_dn;
            up_q   <= 1'b0;
        end else if (up_q) begin
            ramp_q <= r_inc;
            if (r_inc >= hi_w) up_q <= 1'b0;
        end else begin
            ramp_q <= r_dn;
            if (ramp_q <= lo_w + AW'(1)) up_q <= 1'b1;
        end
    end

    assign ev_third_o    = !hold_i && up_q && (r_inc >= lo_w);
    assign ev_top_o      = !hold_i && up_q && (r_inc >= hi_w);
    assign ev_bot_o      = !hold_i && !up_q && (ramp_q <= lo_w + AW'(1));
    assign below_sixth_o = ramp_q < sixth_w;
endmodule

// File: rtl/fbs_fsm.sv
module fbs_fsm
    import fbs_pkg::*;
#(
    parameter int RW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_i,
    input  logic          fault_i,
    input  logic          hold_i,
    input  logic          ev_third_i,
    input  logic          ev_top_i,
    input  logic          ev_bot_i,
    input  logic          below_sixth_i,
    input  logic [RW-1:0] dead_i,
    output bridge_state_e state_o,
    output logic          lo1_o,
    output logic          lo2_o,
    output logic          ho1_o,
    output logic          ho2_o
);
    bridge_state_e st_q, st_nxt;
    logic [RW-1:0] gap_q;
    logic          gap_done, in_gap;

    assign in_gap   = (st_q == ST_DEAD_A) || (st_q == ST_DEAD_B);
    assign gap_done = RW'(gap_q + RW'(1)) >= dead_i;

    always_comb begin
        st_nxt = st_q;
        if (!pwr_i)                      st_nxt = ST_LOCKOUT;
        else if (fault_i)                st_nxt = ST_FAULT;
        else if (hold_i && below_sixth_i) st_nxt = ST_HALT;
        else begin
            unique case (st_q)
                ST_LOCKOUT:   st_nxt = ST_PRECHARGE;
                ST_PRECHARGE: if (ev_third_i) st_nxt = ST_DEAD_A;
                ST_DEAD_A:    if (gap_done)   st_nxt = ST_PAIR_A;
                ST_PAIR_A:    if (ev_top_i)   st_nxt = ST_DEAD_B;
                ST_DEAD_B:    if (gap_done)   st_nxt = ST_PAIR_B;
                ST_PAIR_B:    if (ev_bot_i)   st_nxt = ST_DEAD_A;
                ST_HALT:      if (ev_third_i) st_nxt = ST_DEAD_A;
                ST_FAULT:     st_nxt = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_LOCKOUT;
            gap_q <= '0;
        end else begin
            st_q  <= st_nxt;
            gap_q <= (in_gap && st_nxt == st_q) ? gap_q + RW'(1) : '0;
        end
    end

    always_comb begin
        lo1_o = 1'b0;
        lo2_o = 1'b0;
        ho1_o = 1'b0;
        ho2_o = 1'b0;
        unique case (st_q)
            ST_PRECHARGE: begin lo1_o = 1'b1; lo2_o = 1'b1; end
            ST_PAIR_A:    begin lo1_o = 1'b1; ho2_o = 1'b1; end
            ST_PAIR_B:    begin lo2_o = 1'b1; ho1_o = 1'b1; end
            ST_LOCKOUT, ST_DEAD_A, ST_DEAD_B, ST_HALT, ST_FAULT: ;
        endcase
    end

    assign state_o = st_q;

    assert_lockout_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_i |=> st_q == ST_LOCKOUT);
    assert_fault_over_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAULT && pwr_i) |=> st_q == ST_FAULT);
    assert_halt_below_sixth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_HALT) |-> $past(below_sixth_i));
endmodule

// File: rtl/fbridge_seq.sv
module fbridge_seq
    import fbs_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd_above_on_i,
    input  logic             vdd_above_off_i,
    input  logic             shutdown_i,
    input  logic             ramp_hold_i,
    input  logic [CNT_W-1:0] half_period_i,
    input  logic [CNT_W-1:0] dead_time_i,
    output logic             lo1_o,
    output logic             lo2_o,
    output logic             ho1_o,
    output logic             ho2_o,
    output logic             boot1_en_o,
    output logic             boot2_en_o
);
    localparam int RW = CNT_W + 1;

    logic [3:0]    raw_in, sync_in;
    logic          on_s, off_s, sd_s, hold_s;
    logic [RW-1:0] dead_c, half_c, dead_q, half_q;
    logic          pwr_q, fault_q;
    logic          ev_third, ev_top, ev_bot, below_sixth;
    logic          run_zero;
    bridge_state_e state;

    assign raw_in = {vdd_above_on_i, vdd_above_off_i, shutdown_i, ramp_hold_i};
    fbs_sync #(.W(4)) i_sync (.clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_in));
    assign {on_s, off_s, sd_s, hold_s} = sync_in;

    assign dead_c = (dead_time_i == '0) ? RW'(1) : RW'(dead_time_i);
    assign half_c = (RW'(half_period_i) <= dead_c) ? dead_c + RW'(1) : RW'(half_period_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dead_q  <= RW'(1);
            half_q  <= RW'(2);
            pwr_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            dead_q <= dead_c;
            half_q <= half_c;
            pwr_q  <= pwr_q ? off_s : on_s;
            if (!off_s)              fault_q <= 1'b0;
            else if (pwr_q && sd_s)  fault_q <= 1'b1;
        end
    end

    assign run_zero = (state == ST_LOCKOUT) || (state == ST_FAULT);

    fbs_ramp #(.RW(RW)) i_ramp (
        .clk(clk), .rst_n(rst_n), .zero_i(run_zero), .hold_i(hold_s),
        .third_i(half_q), .ev_third_o(ev_third), .ev_top_o(ev_top),
        .ev_bot_o(ev_bot), .below_sixth_o(below_sixth)
    );

    fbs_fsm #(.RW(RW)) i_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_i(pwr_q), .fault_i(fault_q | sd_s),
        .hold_i(hold_s), .ev_third_i(ev_third), .ev_top_i(ev_top),
        .ev_bot_i(ev_bot), .below_sixth_i(below_sixth), .dead_i(dead_q),
        .state_o(state), .lo1_o(lo1_o), .lo2_o(lo2_o), .ho1_o(ho1_o), .ho2_o(ho2_o)
    );

    assign boot1_en_o = lo1_o;
    assign boot2_en_o = lo2_o;

    assert_no_shoot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo1_o && ho1_o) && !(lo2_o && ho2_o));
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && off_s) |=> fault_q);
    assert_cfg_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_q != '0) && (half_q > dead_q));
endmodule

// File: tb/test_fbridge_seq.sv
`timescale 1ns/1ps
module test_fbridge_seq;
    localparam int CW = 12;
    localparam logic [3:0] PRE = 4'b1100;
    localparam logic [3:0] PA  = 4'b1001;
    localparam logic [3:0] PB  = 4'b0110;
    // {P in, D in, expected P, expected D}
    localparam int VEC [0:4][0:3] = '{
        '{10, 3, 10, 3}, '{20, 1, 20, 1}, '{6, 0, 6, 1}, '{4, 7, 8, 7}, '{2, 1, 2, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic von = 1'b0, voff = 1'b0, sd = 1'b0, hold = 1'b0;
    logic [CW-1:0] half = 12'd10, dead = 12'd3;
    logic lo1, lo2, ho1, ho2, b1, b2;
    int n_chk = 0, n_fail = 0, shoot = 0, bmis = 0;

    always #2 clk = ~clk;

    fbridge_seq #(.CNT_W(CW)) i_fbridge_seq (
        .clk(clk), .rst_n(rst_n), .vdd_above_on_i(von), .vdd_above_off_i(voff),
        .shutdown_i(sd), .ramp_hold_i(hold), .half_period_i(half), .dead_time_i(dead),
        .lo1_o(lo1), .lo2_o(lo2), .ho1_o(ho1), .ho2_o(ho2),
        .boot1_en_o(b1), .boot2_en_o(b2)
    );

    function automatic logic [3:0] pat();
        return {lo1, lo2, ho1, ho2};
    endfunction

    always @(negedge clk) if (rst_n) begin
        if ((lo1 && ho1) || (lo2 && ho2)) shoot++;
        if (b1 != lo1 || b2 != lo2) bmis++;
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pat(logic [3:0] p, int max, output int ok);
        int k = 0;
        while (pat() != p && k < max) begin @(negedge clk); k++; end
        ok = (pat() == p) ? 1 : 0;
    endtask

    task automatic run_len(logic [3:0] p, output int n);
        n = 0;
        while (pat() == p && n < 20000) begin n++; @(negedge clk); end
    endtask

    task automatic activity(int cycles, output int nz);
        nz = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pat() != 4'b0000 || b1 || b2) nz++;
        end
    endtask

    task automatic power_cycle(int p, int d);
        von = 1'b0; voff = 1'b0;
        repeat (8) @(negedge clk);
        half = CW'(p); dead = CW'(d);
        repeat (3) @(negedge clk);
        von = 1'b1; voff = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int ok, n, nz, ep, ed;
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset", {28'd0, pat()}, 0);
        rst_n = 1'b1;
        activity(20, nz);
        check("R1", "no activity with supply low", nz, 0);

        for (int i = 0; i < 5; i++) begin
            ep = VEC[i][2]; ed = VEC[i][3];
            power_cycle(VEC[i][0], VEC[i][1]);
            wait_pat(PRE, 100, ok);
            check("R3", "precharge seen", ok, 1);
            run_len(PRE, n);  check("R3", "precharge length", n, ep);
            run_len(4'b0, n); check("R6", "gap after precharge", n, ed);
            run_len(PA, n);   check("R4", "pair A length", n, ep - ed);
            run_len(4'b0, n); check("R6", "gap before pair B", n, ed);
            run_len(PB, n);   check("R5", "pair B length", n, ep - ed);
            run_len(4'b0, n); check("R6", "gap before pair A", n, ed);
            if (i >= 2) check("R9", "clamped pattern resumes", {28'd0, pat()}, PA);
        end

        // R2: hysteresis
        power_cycle(10, 3);
        wait_pat(PA, 200, ok);
        von = 1'b0;
        activity(60, nz);
        check("R2", "runs between thresholds", (nz > 0) ? 1 : 0, 1);
        voff = 1'b0;
        repeat (6) @(negedge clk);
        activity(30, nz);
        check("R2", "stops below turn-off", nz, 0);
        voff = 1'b1;
        activity(40, nz);
        check("R2", "stays off without turn-on flag", nz, 0);
        von = 1'b1;
        wait_pat(PRE, 20, ok);
        check("R2", "restart on turn-on flag", ok, 1);

        // R7: latched fault
        wait_pat(PA, 200, ok);
        sd = 1'b1; repeat (3) @(negedge clk); sd = 1'b0;
        repeat (3) @(negedge clk);
        activity(60, nz);
        check("R7", "fault holds outputs low", nz, 0);
        von = 1'b0; repeat (10) @(negedge clk); von = 1'b1;
        activity(60, nz);
        check("R7", "turn-on flag drop does not clear", nz, 0);
        von = 1'b0; voff = 1'b0; repeat (10) @(negedge clk);
        von = 1'b1; voff = 1'b1;
        wait_pat(PRE, 40, ok);
        check("R7", "undervoltage cycle clears fault", ok, 1);

        // R8: non-latched hold
        wait_pat(PA, 200, ok);
        hold = 1'b1;
        repeat (40) @(negedge clk);
        activity(40, nz);
        check("R8", "hold stops bridge and charging", nz, 0);
        hold = 1'b0;
        n = 0;
        while (pat() == 4'b0 && n < 200) begin @(negedge clk); n++; end
        check("R8", "first pattern after release", {28'd0, pat()}, PA);

        // R11: fault outranks hold
        wait_pat(PA, 200, ok);
        hold = 1'b1; sd = 1'b1;
        repeat (4) @(negedge clk);
        sd = 1'b0; hold = 1'b0;
        repeat (3) @(negedge clk);
        activity(80, nz);
        check("R11", "fault stays after hold release", nz, 0);
        voff = 1'b0; von = 1'b0; repeat (10) @(negedge clk);
        voff = 1'b1; von = 1'b1;
        wait_pat(PRE, 40, ok);
        check("R11", "restart after fault clear", ok, 1);

        check("R6", "shoot-through cycles", shoot, 0);
        check("R10", "charging enable mismatches", bmis, 0);
        summary();
    end
endmodule